// File: doc/BRIEF.md
# Segmented Data Bus Inversion Codec

This block sits between a 64-bit logical data path and an active-low parallel data bus. On the transmit side it turns each logical data phase into electrical line levels. A logical one is an electrical low, and a deasserted inversion flag is an electrical high. The 64 lines are split into four 16-bit segments. Each segment gets its own inversion flag, so no segment ever pulls more than half of its lines low. On the receive side, the block takes the bus levels and the four flags and restores the logical word.

The block accepts one data phase per cycle on each path. A valid bit travels alongside the data, and both paths have one registered stage. A phase counter on the transmit side groups the accepted phases into cache-line bursts of eight. It marks the first phase and the last phase of each burst, and these marks come out together with the encoded data.

Top module: `dbi_seg_codec`

## Requirements
- R1: Flag k covers data bits 16k+15 down to 16k, for k = 0 to 3. A logical 1 appears as electrical 0 on the bus. A flag is asserted when its electrical level is 0.
- R2: On transmit, suppose the logical segment contains more than eight ones, so more than eight lines would be driven low. Then the segment is sent inverted: the bus carries the logical bits unchanged, and the segment's flag is driven to 0.
- R3: On transmit, suppose the logical segment contains eight or fewer ones, including exactly eight. Then the bus carries the bitwise complement of the logical bits, and the flag stays at 1.
- R4: The inversion decision for each segment depends only on that segment's bits in the current phase. It does not depend on other segments or on earlier phases.
- R5: A valid transmitted phase never has more than eight electrically low lines in any segment.
- R6: A transmit phase accepted while tx_valid_i is high appears on the outputs exactly one cycle later, with tx_valid_o high. In a cycle after tx_valid_i was low, tx_valid_o is 0, every bus line is 1, and every flag is 1.
- R7: On receive, if a segment's flag is 0, the restored segment equals the bus bits; if the flag is 1, it equals their complement. The result and rx_valid_o appear one cycle after the input. After an invalid input, rx_data_o is all zeros and rx_valid_o is 0.
- R8: Passing the encoder's outputs into the decoder returns the original 64-bit word for every input value, including all zeros and all ones.
- R9: The phase counter advances only on accepted transmit phases and wraps after eight. tx_first_o is 1 on the output for phase 0 of each burst, and tx_last_o is 1 for phase 7. Both are 0 on every other phase and whenever tx_valid_o is 0.
- R10: During reset, the phase counter returns to 0. Both valid outputs and both burst marks go to 0, all bus lines and flags go to 1, and rx_data_o goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid_i | input | 1 | Transmit phase present |
| tx_data_i | input | 64 | Logical transmit word |
| tx_valid_o | output | 1 | Encoded phase present |
| tx_bus_o | output | 64 | Electrical data line levels |
| tx_flag_n_o | output | 4 | Active-low inversion flags, one per segment |
| tx_first_o | output | 1 | First phase of a burst |
| tx_last_o | output | 1 | Last phase of a burst |
| rx_valid_i | input | 1 | Received phase present |
| rx_bus_i | input | 64 | Received electrical line levels |
| rx_flag_n_i | input | 4 | Received active-low inversion flags |
| rx_valid_o | output | 1 | Restored word present |
| rx_data_o | output | 64 | Restored logical word |

## Verification
Some properties are checked by assertions on every cycle:
- the low-line bound in each segment;
- the tighter bound that any inverted segment must satisfy;
- the idle level whenever the transmit output is invalid;
- the one-cycle valid latency on both paths;
- the ordering of the burst marks.

Only the bench scenarios can confirm the exact encoded values. These include the behaviour at exactly eight versus nine ones, the encode-then-decode identity over a full sweep of 16-bit segment patterns, counter wrap across gaps in valid, and decoding under arbitrary flag combinations.

// File: rtl/dbi_seg_codec.sv
module dbi_seg_codec #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4,
  parameter int BEATS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tx_valid_i,
  input  logic [SEG_W*NSEG-1:0]  tx_data_i,
  output logic                   tx_valid_o,
  output logic [SEG_W*NSEG-1:0]  tx_bus_o,
  output logic [NSEG-1:0]        tx_flag_n_o,
  output logic                   tx_first_o,
  output logic                   tx_last_o,
  input  logic                   rx_valid_i,
  input  logic [SEG_W*NSEG-1:0]  rx_bus_i,
  input  logic [NSEG-1:0]        rx_flag_n_i,
  output logic                   rx_valid_o,
  output logic [SEG_W*NSEG-1:0]  rx_data_o
);
  localparam int DW = SEG_W * NSEG;
  localparam int CW = $clog2(SEG_W + 1);
  localparam int PW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LIM  = CW'(SEG_W / 2);
  localparam logic [PW-1:0] LAST = PW'(BEATS - 1);

  function automatic logic [CW-1:0] ones(input logic [SEG_W-1:0] x);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < SEG_W; i++) n = n + CW'(x[i]);
    return n;
  endfunction

  logic [NSEG-1:0] inv;
  logic [DW-1:0]   enc_bus;
  logic [DW-1:0]   dec_data;
  logic [PW-1:0]   phase;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEG_W-1:0] seg;
    assign seg    = tx_data_i[g*SEG_W +: SEG_W];
    assign inv[g] = ones(seg) > LIM;
    assign enc_bus[g*SEG_W +: SEG_W]  = inv[g] ? seg : ~seg;
    assign dec_data[g*SEG_W +: SEG_W] = rx_flag_n_i[g] ? ~rx_bus_i[g*SEG_W +: SEG_W]
                                                       :  rx_bus_i[g*SEG_W +: SEG_W];

    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o |-> ($countones(~tx_bus_o[g*SEG_W +: SEG_W]) <= (SEG_W / 2))); // R5
    AST_INV_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_flag_n_o[g]) |-> ($countones(~tx_bus_o[g*SEG_W +: SEG_W]) < (SEG_W / 2))); // R2
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid_o  <= 1'b0;
      tx_bus_o    <= '1;
      tx_flag_n_o <= '1;
      tx_first_o  <= 1'b0;
      tx_last_o   <= 1'b0;
      phase       <= '0;
    end else begin
      tx_valid_o <= tx_valid_i;
      if (tx_valid_i) begin
        tx_bus_o    <= enc_bus;
        tx_flag_n_o <= ~inv;
        tx_first_o  <= (phase == '0);
        tx_last_o   <= (phase == LAST);
        phase       <= (phase == LAST) ? '0 : phase + PW'(1);
      end else begin
        tx_bus_o    <= '1;
        tx_flag_n_o <= '1;
        tx_first_o  <= 1'b0;
        tx_last_o   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= rx_valid_i;
      rx_data_o  <= rx_valid_i ? dec_data : '0;
    end
  end

  AST_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid_o |-> ((&tx_bus_o) && (&tx_flag_n_o) && !tx_first_o && !tx_last_o)); // R6
  AST_TX_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_i |=> tx_valid_o); // R6
  AST_RX_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i |=> rx_valid_o); // R7
  AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_i |=> (!rx_valid_o && (rx_data_o == '0))); // R7
  AST_MID_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_last_o) |=> !tx_first_o); // R9
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && tx_last_o && tx_valid_i) |=> tx_first_o); // R9
endmodule

// File: tb/dbi_seg_codec_tb.sv
module dbi_seg_codec_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        tx_valid_i = 1'b0;
  logic [63:0] tx_data_i = '0;
  logic        tx_valid_o, tx_first_o, tx_last_o, rx_valid_o;
  logic [63:0] tx_bus_o, rx_data_o;
  logic [3:0]  tx_flag_n_o;
  logic        lb = 1'b1;
  logic        m_valid = 1'b0;
  logic [63:0] m_bus = '0;
  logic [3:0]  m_flag = '1;
  logic        rx_valid_i;
  logic [63:0] rx_bus_i;
  logic [3:0]  rx_flag_n_i;

  assign rx_valid_i  = lb ? tx_valid_o  : m_valid;
  assign rx_bus_i    = lb ? tx_bus_o    : m_bus;
  assign rx_flag_n_i = lb ? tx_flag_n_o : m_flag;

  dbi_seg_codec u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .tx_valid_o(tx_valid_o), .tx_bus_o(tx_bus_o), .tx_flag_n_o(tx_flag_n_o),
    .tx_first_o(tx_first_o), .tx_last_o(tx_last_o),
    .rx_valid_i(rx_valid_i), .rx_bus_i(rx_bus_i), .rx_flag_n_i(rx_flag_n_i),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
  );

  int checks = 0;
  int errors = 0;
  int cnt = 0;
  logic        prev_v = 1'b0;
  logic [63:0] prev_d = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [67:0] enc(input logic [63:0] d);
    logic [63:0] b;
    logic [3:0]  f;
    for (int k = 0; k < 4; k++) begin
      if ($countones(d[k*16 +: 16]) > 8) begin
        b[k*16 +: 16] = d[k*16 +: 16]; f[k] = 1'b0;
      end else begin
        b[k*16 +: 16] = ~d[k*16 +: 16]; f[k] = 1'b1;
      end
    end
    return {f, b};
  endfunction

  task automatic step(input logic v, input logic [63:0] d);
    logic [67:0] e;
    logic fe, le;
    tx_valid_i = v; tx_data_i = d;
    @(negedge clk);
    e = enc(d);
    fe = v && (cnt == 0);
    le = v && (cnt == 7);
    chk(tx_valid_o == v, "R6 valid", {63'd0, tx_valid_o}, {63'd0, v});
    if (v) begin
      chk(tx_bus_o == e[63:0], "R2/R3 bus", tx_bus_o, e[63:0]);
      chk(tx_flag_n_o == e[67:64], "R1 flags", {60'd0, tx_flag_n_o}, {60'd0, e[67:64]});
      for (int k = 0; k < 4; k++)
        chk($countones(~tx_bus_o[k*16 +: 16]) <= 8, "R5 low count", tx_bus_o, e[63:0]);
      cnt = (cnt + 1) % 8;
    end else begin
      chk(tx_bus_o == '1 && tx_flag_n_o == '1, "R6 idle", tx_bus_o, '1);
    end
    chk(tx_first_o == fe && tx_last_o == le, "R9 markers",
        {62'd0, tx_first_o, tx_last_o}, {62'd0, fe, le});
    chk(rx_valid_o == prev_v, "R7 rx valid", {63'd0, rx_valid_o}, {63'd0, prev_v});
    chk(rx_data_o == (prev_v ? prev_d : 64'd0), "R8 round trip", rx_data_o, prev_v ? prev_d : 64'd0);
    prev_v = v; prev_d = d;
  endtask

  task automatic rx_step(input logic v, input logic [63:0] b, input logic [3:0] f);
    logic [63:0] x;
    m_valid = v; m_bus = b; m_flag = f; tx_valid_i = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) x[k*16 +: 16] = f[k] ? ~b[k*16 +: 16] : b[k*16 +: 16];
    if (!v) x = '0;
    chk(rx_valid_o == v, "R7 valid", {63'd0, rx_valid_o}, {63'd0, v});
    chk(rx_data_o == x, "R7 decode", rx_data_o, x);
    chk(!tx_valid_o && tx_bus_o == '1, "R6 idle", tx_bus_o, '1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_bus_o == '1 && tx_flag_n_o == '1, "R10 bus", tx_bus_o, '1);
    chk(!tx_valid_o && !rx_valid_o && !tx_first_o && !tx_last_o, "R10 ctrl",
        {60'd0, tx_valid_o, rx_valid_o, tx_first_o, tx_last_o}, '0);
    chk(rx_data_o == '0, "R10 rx data", rx_data_o, '0);
    rst_n = 1'b1;
    step(1'b1, 64'h0);                    // R3 all zeros
    step(1'b1, '1);                       // R2 all ones
    step(1'b1, 64'h00FF_01FF_FF00_0001);  // R4 mixed, R3 exactly eight
    step(1'b1, 64'h01FF_00FF_0001_FF80);  // R2 nine ones
    for (int i = 0; i < 65536; i++) begin // R8 sweep
      logic [15:0] v;
      v = 16'(i);
      step(1'b1, {v, ~v, v[7:0], v[15:8], v ^ 16'h5A5A});
    end
    for (int i = 0; i < 60; i++)          // R9 gaps
      step((i % 3) != 0, {4{16'(i * 977)}});
    step(1'b0, '1);
    lb = 1'b0;
    for (int i = 0; i < 512; i++)         // R7 flag combinations
      rx_step(i[4] | i[0], {$urandom, $urandom}, 4'(i));
    rst_n = 1'b0;
    @(negedge clk);
    chk(tx_bus_o == '1 && !rx_valid_o && rx_data_o == '0, "R10 re-reset", tx_bus_o, '1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule